// File: doc/BRIEF.md
# Diagnostic threshold flag generator

This block watches five 16-bit monitor readings of an optical link module: internal temperature, supply voltage, laser bias current, transmitted optical power and received optical power. It compares each reading against four stored limits and produces alarm and warning flags. Each quantity has a high-alarm, low-alarm, high-warning and low-warning limit. The host loads the 40-byte limit table through a byte-wide write port. The resulting flags are read back as bytes at fixed offsets of a small read port.

A new set of readings is taken when the sample strobe is high. The flags are recomputed on that clock edge and then hold until the next strobe. Flags are not latched: each one reflects only the latest comparison.

Top module: `diag_flag_gen`

## Requirements
- R1: The limit table holds 40 bytes. Quantity q (0 temperature, 1 supply, 2 bias, 3 transmit power, 4 receive power) and limit k (0 high alarm, 1 low alarm, 2 high warning, 3 low warning) sit at byte addresses q*8+k*2 (upper byte) and q*8+k*2+1 (lower byte).
- R2: Temperature readings and limits are compared as signed two's-complement numbers.
- R3: Supply, bias and both optical power readings are compared as unsigned numbers.
- R4: A high flag is set only when the reading is strictly above its high limit. A low flag is set only when the reading is strictly below its low limit. A reading equal to a limit sets no flag.
- R5: Read offset 0 returns the first alarm byte. From bit 7 down to bit 0 it holds temperature high/low, supply high/low, bias high/low and transmit power high/low.
- R6: Read offset 1 returns the second alarm byte. Bit 7 is receive power high, bit 6 is receive power low, and bits 5..0 read 0.
- R7: Read offsets 4 and 5 return the warning bytes, using the same bit layout as offsets 0 and 1.
- R8: Read offsets 2, 3, 6 and 7 return 0.
- R9: The flags take new values on the clock edge where the sample strobe is high, so they are visible one cycle after the strobe. Between strobes they hold, whatever the readings do.
- R10: Flags are live. A flag set by one sample clears at the next sample whose reading lies within the limit.
- R11: After reset all flags read 0. Every high limit resets to its type's maximum (0x7FFF for temperature, 0xFFFF otherwise). Every low limit resets to its type's minimum (0x8000 for temperature, 0x0000 otherwise). As a result, extreme readings raise no flag until limits are written.
- R12: Writes to limit addresses 40 to 63 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Limit table byte write enable |
| thr_addr | input | 6 | Limit table byte address |
| thr_wdata | input | 8 | Limit table write byte |
| smp_valid | input | 1 | Sample strobe for the readings |
| temp_in | input | 16 | Temperature reading (signed) |
| vcc_in | input | 16 | Supply voltage reading |
| bias_in | input | 16 | Laser bias reading |
| txp_in | input | 16 | Transmit power reading |
| rxp_in | input | 16 | Receive power reading |
| rd_addr | input | 3 | Flag byte read offset |
| rd_data | output | 8 | Flag byte at rd_addr (combinational) |

## Verification
A vector table drives each quantity on its own, both above and below its limits. Some readings land exactly on a limit, which separates strict from inclusive compares. Others fall between the warning and alarm limits, which separates the two flag sets. A negative temperature and a bias reading with its top bit set tell signed compares from unsigned ones. A vector with every quantity out of range at once exposes bit-packing errors. Directed steps cover the rest: strobe timing, holding between strobes, clearing on return, the reset limits, single-byte limit edits that show which byte is the upper one, and writes past the table end.

// File: rtl/diag_flag_pkg.sv
package diag_flag_pkg;

    localparam int VAL_W       = 16;
    localparam int NUM_QTY     = 5;
    localparam int THR_PER_QTY = 4;
    localparam int BYTES_PER_V = VAL_W / 8;
    localparam int TBL_BYTES   = NUM_QTY * THR_PER_QTY * BYTES_PER_V;
    localparam int TBL_AW      = $clog2(TBL_BYTES);
    localparam int RD_AW       = 3;
    localparam int FLAG_PAIR_W = 16;

    // Quantities whose compare is signed (bit index = quantity index)
    localparam logic [NUM_QTY-1:0] QTY_SIGNED = 5'b00001;

    typedef enum logic [2:0] {
        Q_TEMP = 3'd0,
        Q_VCC  = 3'd1,
        Q_BIAS = 3'd2,
        Q_TXP  = 3'd3,
        Q_RXP  = 3'd4
    } qty_e;

    typedef logic [VAL_W-1:0] val_t;

    typedef struct packed {
        val_t hi_alm;
        val_t lo_alm;
        val_t hi_wrn;
        val_t lo_wrn;
    } thr_set_t;

    typedef struct packed {
        logic hi_alm;
        logic lo_alm;
        logic hi_wrn;
        logic lo_wrn;
    } cmp_res_t;

    // Reset value of limit k for a quantity of the given signedness
    function automatic val_t thr_reset_val(input logic sgn, input int k);
        logic is_high;
        is_high = (k == 0) || (k == 2);
        if (is_high) return sgn ? {1'b0, {(VAL_W-1){1'b1}}} : {VAL_W{1'b1}};
        else         return sgn ? {1'b1, {(VAL_W-1){1'b0}}} : {VAL_W{1'b0}};
    endfunction

    // Reset value of one table byte, upper byte at the lower address
    function automatic logic [7:0] tbl_reset_byte(input int idx);
        int   q;
        int   k;
        int   b;
        val_t v;
        q = idx / (THR_PER_QTY * BYTES_PER_V);
        k = (idx / BYTES_PER_V) % THR_PER_QTY;
        b = idx % BYTES_PER_V;
        v = thr_reset_val(QTY_SIGNED[q], k);
        return v[VAL_W-1-8*b -: 8];
    endfunction

endpackage

// File: rtl/diag_thr_regs.sv
module diag_thr_regs
    import diag_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [TBL_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output thr_set_t          thr [NUM_QTY]
);
    localparam logic [TBL_AW-1:0] LAST_ADDR = TBL_AW'(TBL_BYTES - 1);

    logic [7:0]             tbl [TBL_BYTES];
    logic [TBL_BYTES*8-1:0] tbl_flat;
    logic                   wr_ok;

    assign wr_ok = we && (addr <= LAST_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_BYTES; i++) tbl[i] <= tbl_reset_byte(i);
        end else if (wr_ok) begin
            tbl[addr] <= wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < TBL_BYTES; i++) tbl_flat[i*8 +: 8] = tbl[i];
    end

    // Assemble limits: upper byte at the even address
    for (genvar q = 0; q < NUM_QTY; q++) begin : g_qty
        localparam int BASE = q * THR_PER_QTY * BYTES_PER_V;
        assign thr[q].hi_alm = {tbl[BASE+0], tbl[BASE+1]};
        assign thr[q].lo_alm = {tbl[BASE+2], tbl[BASE+3]};
        assign thr[q].hi_wrn = {tbl[BASE+4], tbl[BASE+5]};
        assign thr[q].lo_wrn = {tbl[BASE+6], tbl[BASE+7]};
    end

    p_wr_store_r1: assert property (@(posedge clk) disable iff (rst)
        (we && addr <= LAST_ADDR) |=> tbl[$past(addr)] == $past(wdata));

    p_oob_ignore_r12: assert property (@(posedge clk) disable iff (rst)
        (we && addr > LAST_ADDR) |=> $stable(tbl_flat));

endmodule

// File: rtl/diag_cmp_unit.sv
module diag_cmp_unit
    import diag_flag_pkg::*;
#(
    parameter bit SIGNED_CMP = 1'b0
) (
    input  val_t     value,
    input  thr_set_t thr,
    output cmp_res_t res
);
    if (SIGNED_CMP) begin : g_signed
        always_comb begin
            res.hi_alm = $signed(value) > $signed(thr.hi_alm);
            res.lo_alm = $signed(value) < $signed(thr.lo_alm);
            res.hi_wrn = $signed(value) > $signed(thr.hi_wrn);
            res.lo_wrn = $signed(value) < $signed(thr.lo_wrn);
        end
    end else begin : g_unsigned
        always_comb begin
            res.hi_alm = value > thr.hi_alm;
            res.lo_alm = value < thr.lo_alm;
            res.hi_wrn = value > thr.hi_wrn;
            res.lo_wrn = value < thr.lo_wrn;
        end
    end
endmodule

// File: rtl/diag_flag_pack.sv
module diag_flag_pack
    import diag_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp,
    input  cmp_res_t         res [NUM_QTY],
    input  logic [RD_AW-1:0] rd_addr,
    output logic [7:0]       rd_data
);
    localparam int FLAG_W = 2 * NUM_QTY;
    localparam int PAD_W  = FLAG_PAIR_W - FLAG_W;

    logic [FLAG_W-1:0]      alm_nxt, wrn_nxt;
    logic [FLAG_W-1:0]      alm_q, wrn_q;
    logic [FLAG_PAIR_W-1:0] alm_pair, wrn_pair;

    // Quantity 0 takes the top bit pair
    for (genvar q = 0; q < NUM_QTY; q++) begin : g_bits
        localparam int HI = 2 * (NUM_QTY - 1 - q) + 1;
        assign alm_nxt[HI]   = res[q].hi_alm;
        assign alm_nxt[HI-1] = res[q].lo_alm;
        assign wrn_nxt[HI]   = res[q].hi_wrn;
        assign wrn_nxt[HI-1] = res[q].lo_wrn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
            wrn_q <= '0;
        end else if (smp) begin
            alm_q <= alm_nxt;
            wrn_q <= wrn_nxt;
        end
    end

    assign alm_pair = {alm_q, {PAD_W{1'b0}}};
    assign wrn_pair = {wrn_q, {PAD_W{1'b0}}};

    always_comb begin
        case (rd_addr)
            3'd0:    rd_data = alm_pair[15:8];
            3'd1:    rd_data = alm_pair[7:0];
            3'd4:    rd_data = wrn_pair[15:8];
            3'd5:    rd_data = wrn_pair[7:0];
            default: rd_data = 8'h00;
        endcase
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !smp |=> ($stable(alm_q) && $stable(wrn_q)));

    p_resv_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 3'd2 || rd_addr == 3'd3 || rd_addr == 3'd6 || rd_addr == 3'd7)
        |-> rd_data == 8'h00);

    p_rx_slot_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 3'd1 || rd_addr == 3'd5) |-> rd_data[5:0] == 6'd0);

endmodule

// File: rtl/diag_flag_gen.sv
module diag_flag_gen
    import diag_flag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                thr_we,
    input  logic [TBL_AW-1:0]   thr_addr,
    input  logic [7:0]          thr_wdata,
    input  logic                smp_valid,
    input  logic [VAL_W-1:0]    temp_in,
    input  logic [VAL_W-1:0]    vcc_in,
    input  logic [VAL_W-1:0]    bias_in,
    input  logic [VAL_W-1:0]    txp_in,
    input  logic [VAL_W-1:0]    rxp_in,
    input  logic [RD_AW-1:0]    rd_addr,
    output logic [7:0]          rd_data
);
    thr_set_t thr  [NUM_QTY];
    cmp_res_t res  [NUM_QTY];
    val_t     rdg  [NUM_QTY];

    assign rdg[Q_TEMP] = temp_in;
    assign rdg[Q_VCC]  = vcc_in;
    assign rdg[Q_BIAS] = bias_in;
    assign rdg[Q_TXP]  = txp_in;
    assign rdg[Q_RXP]  = rxp_in;

    diag_thr_regs u_thr (
        .clk   (clk),
        .rst   (rst),
        .we    (thr_we),
        .addr  (thr_addr),
        .wdata (thr_wdata),
        .thr   (thr)
    );

    for (genvar q = 0; q < NUM_QTY; q++) begin : g_cmp
        diag_cmp_unit #(.SIGNED_CMP(QTY_SIGNED[q])) u_cmp (
            .value (rdg[q]),
            .thr   (thr[q]),
            .res   (res[q])
        );

        p_strict_hi_r4: assert property (@(posedge clk) disable iff (rst)
            (rdg[q] == thr[q].hi_alm) |-> !res[q].hi_alm);
        p_strict_lo_r4: assert property (@(posedge clk) disable iff (rst)
            (rdg[q] == thr[q].lo_wrn) |-> !res[q].lo_wrn);
    end

    diag_flag_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp_valid),
        .res     (res),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Negative temperature never exceeds a non-negative high limit
    p_temp_signed_r2: assert property (@(posedge clk) disable iff (rst)
        (temp_in[VAL_W-1] && !thr[Q_TEMP].hi_alm[VAL_W-1]) |-> !res[Q_TEMP].hi_alm);

    // Bias with top bit set always exceeds a limit whose top bit is clear
    p_bias_unsigned_r3: assert property (@(posedge clk) disable iff (rst)
        (bias_in[VAL_W-1] && !thr[Q_BIAS].hi_alm[VAL_W-1]) |-> res[Q_BIAS].hi_alm);

endmodule

// File: tb/diag_flag_gen_tb.sv
`timescale 1ns/1ps
module diag_flag_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        thr_we = 1'b0;
    logic [5:0]  thr_addr = '0;
    logic [7:0]  thr_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] temp_in = '0, vcc_in = '0, bias_in = '0, txp_in = '0, rxp_in = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    diag_flag_gen u_dut (
        .clk(clk), .rst(rst), .thr_we(thr_we), .thr_addr(thr_addr),
        .thr_wdata(thr_wdata), .smp_valid(smp_valid), .temp_in(temp_in),
        .vcc_in(vcc_in), .bias_in(bias_in), .txp_in(txp_in), .rxp_in(rxp_in),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {temp, vcc, bias, txp, rxp, expected alarms, expected warnings}
    // flag vector bit 9..0: temp hi/lo, vcc hi/lo, bias hi/lo, tx hi/lo, rx hi/lo
    localparam int NV = 17;
    localparam logic [99:0] VEC [NV] = '{
        {16'h1900, 16'h8000, 16'h2000, 16'h4000, 16'h5000, 10'h000, 10'h000},
        {16'h5100, 16'h8000, 16'h2000, 16'h4000, 16'h5000, 10'h200, 10'h200},
        {16'hF000, 16'h8000, 16'h2000, 16'h4000, 16'h5000, 10'h100, 10'h100},
        {16'h5000, 16'h8000, 16'h2000, 16'h4000, 16'h5000, 10'h000, 10'h200},
        {16'hF600, 16'h8000, 16'h2000, 16'h4000, 16'h5000, 10'h000, 10'h100},
        {16'h1900, 16'h9001, 16'h2000, 16'h4000, 16'h5000, 10'h080, 10'h080},
        {16'h1900, 16'h7300, 16'h2000, 16'h4000, 16'h5000, 10'h000, 10'h040},
        {16'h1900, 16'h8000, 16'hF000, 16'h4000, 16'h5000, 10'h020, 10'h020},
        {16'h1900, 16'h8000, 16'h0000, 16'h4000, 16'h5000, 10'h010, 10'h010},
        {16'h1900, 16'h8000, 16'h2000, 16'h7000, 16'h5000, 10'h000, 10'h008},
        {16'h1900, 16'h8000, 16'h2000, 16'h0FFF, 16'h5000, 10'h004, 10'h004},
        {16'h1900, 16'h8000, 16'h2000, 16'h4000, 16'hC001, 10'h002, 10'h002},
        {16'h1900, 16'h8000, 16'h2000, 16'h4000, 16'h0000, 10'h001, 10'h001},
        {16'h1900, 16'h8000, 16'h2000, 16'h4000, 16'h0018, 10'h000, 10'h001},
        {16'h1900, 16'h8000, 16'h2000, 16'h8000, 16'h5000, 10'h000, 10'h008},
        {16'h7FFF, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0001, 10'h269, 10'h269},
        {16'h1900, 16'h8000, 16'h2000, 16'h4000, 16'h5000, 10'h000, 10'h000}
    };
    localparam string TAG [NV] = '{
        "R10", "R5", "R2", "R4", "R4", "R3", "R3", "R3", "R3",
        "R7", "R3", "R6", "R6", "R4", "R4", "R5", "R10"
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr_byte(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        thr_we = 1'b1; thr_addr = a; thr_wdata = d;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic wr_thr(input int q, input int k, input logic [15:0] v);
        wr_byte(6'(q*8 + k*2), v[15:8]);
        wr_byte(6'(q*8 + k*2 + 1), v[7:0]);
    endtask

    task automatic sample(input logic [15:0] t, v, b, tx, rx);
        @(negedge clk);
        temp_in = t; vcc_in = v; bias_in = b; txp_in = tx; rxp_in = rx;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic chk_flags(input string req, input logic [9:0] ea, input logic [9:0] ew);
        logic [7:0] d;
        rd(3'd0, d); chk({req, "/R5 alarm0"}, d, ea[9:2]);
        rd(3'd1, d); chk({req, "/R6 alarm1"}, d, {ea[1:0], 6'd0});
        rd(3'd4, d); chk({req, "/R7 warn0"}, d, ew[9:2]);
        rd(3'd5, d); chk({req, "/R7 warn1"}, d, {ew[1:0], 6'd0});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state and reset limits
        chk_flags("R11 reset", 10'h000, 10'h000);
        sample(16'h7FFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        chk_flags("R11 max rdg", 10'h000, 10'h000);
        sample(16'h8000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        chk_flags("R11 min rdg", 10'h000, 10'h000);

        // R1: load limits (q*8 + k*2, upper byte first)
        wr_thr(0, 0, 16'h5000); wr_thr(0, 1, 16'hF600); wr_thr(0, 2, 16'h4600); wr_thr(0, 3, 16'h0000);
        wr_thr(1, 0, 16'h9000); wr_thr(1, 1, 16'h7000); wr_thr(1, 2, 16'h8C00); wr_thr(1, 3, 16'h7400);
        wr_thr(2, 0, 16'h4000); wr_thr(2, 1, 16'h0100); wr_thr(2, 2, 16'h3000); wr_thr(2, 3, 16'h0200);
        wr_thr(3, 0, 16'h8000); wr_thr(3, 1, 16'h1000); wr_thr(3, 2, 16'h6000); wr_thr(3, 3, 16'h2000);
        wr_thr(4, 0, 16'hC000); wr_thr(4, 1, 16'h0010); wr_thr(4, 2, 16'hA000); wr_thr(4, 3, 16'h0020);

        // R9: flags change only on the strobe edge
        @(negedge clk);
        temp_in = 16'h5100; vcc_in = 16'h8000; bias_in = 16'h2000;
        txp_in = 16'h4000; rxp_in = 16'h5000; smp_valid = 1'b1;
        rd(3'd0, d); chk("R9 before edge", d, 8'h00);
        @(negedge clk);
        smp_valid = 1'b0;
        rd(3'd0, d); chk("R9 after edge", d, 8'h80);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            sample(VEC[i][99:84], VEC[i][83:68], VEC[i][67:52], VEC[i][51:36], VEC[i][35:20]);
            chk_flags($sformatf("%s v%0d", TAG[i], i), VEC[i][19:10], VEC[i][9:0]);
        end

        // R8: reserved offsets, with flags set
        sample(16'h7FFF, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0001);
        for (int a = 2; a < 8; a++) begin
            if (a == 4 || a == 5) continue;
            rd(3'(a), d); chk($sformatf("R8 offset %0d", a), d, 8'h00);
        end

        // R9: hold while readings change without a strobe
        @(negedge clk);
        temp_in = 16'h1900; vcc_in = 16'h8000; bias_in = 16'h2000;
        txp_in = 16'h4000; rxp_in = 16'h5000;
        repeat (3) @(negedge clk);
        chk_flags("R9 hold", 10'h269, 10'h269);

        // R10: clears on next in-range sample
        sample(16'h1900, 16'h8000, 16'h2000, 16'h4000, 16'h5000);
        chk_flags("R10 clear", 10'h000, 10'h000);

        // R1: byte order of a single limit (temp high warning at 4/5)
        wr_byte(6'd5, 8'hFF);
        sample(16'h4680, 16'h8000, 16'h2000, 16'h4000, 16'h5000);
        rd(3'd4, d); chk("R1 lower byte", d, 8'h00);
        wr_byte(6'd4, 8'h40);
        sample(16'h4680, 16'h8000, 16'h2000, 16'h4000, 16'h5000);
        rd(3'd4, d); chk("R1 upper byte", d, 8'h80);

        // R12: writes beyond the table are ignored
        for (int a = 40; a < 64; a++) wr_byte(6'(a), 8'h00);
        sample(16'h1900, 16'h8000, 16'h2000, 16'h4000, 16'h5000);
        chk_flags("R12 oob", 10'h000, 10'h000);
        sample(16'h4680, 16'h8000, 16'h2000, 16'h4000, 16'h5000);
        rd(3'd4, d); chk("R12 limit kept", d, 8'h80);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule